// File: doc/BRIEF.md
# Front-End Trigger Sequencer

This block turns a trigger request into the timed pulses that a front-end readout chip needs: a chip trigger, an optional test pulse, an optional chip reset, and a readout-start pulse that opens data recording downstream. Everything runs on one 40 MHz clock domain. A trigger comes either from an external input, which is synchronized and edge-detected with programmable polarity, or from an internal generator that repeats at a programmable period.

Every accepted trigger launches three independent countdowns. Each countdown ends in a single-cycle pulse: chip trigger, test pulse and readout start. After an accepted trigger, further triggers are held off. The hold-off lasts for a period register scaled by 64 clock cycles, and it also lasts while any countdown from the previous trigger is still running. The same scaled period sets the repetition interval of the internal generator. A burst register n is presented downstream as a sample-slot count of (n+1)*3.

Configuration uses a plain write port (write enable, 3-bit address, 16-bit data). Register addresses: 0 mode, 1 burst, 2 period, 3 chip-trigger delay, 4 test-pulse delay, 5 readout-start delay, 6 run enable. Mode bits: bit 3 inverts the trigger input, bit 2 selects the source (1 external, 0 internal), bit 1 enables the test pulse, and bit 0 enables the chip reset pulse.

Top module: `trig_sequencer`

## Requirements
- R1: After reset, all pulse outputs are low and burst_slots_o equals 15, which is the value for the default burst n = 4.
- R2: Writing n to address 1 makes burst_slots_o equal (n+1)*3 from the next cycle on. A written value above 9 is stored as 9, which gives 30.
- R3: The external input passes through two synchronizing flops. In external mode, a polarity-corrected rising edge of trig_in is accepted when the block is free. accept_o then pulses for one cycle, at the third rising clock edge after trig_in changes.
- R4: When mode bit 3 is 1, the input is inverted, so a falling edge of trig_in is what triggers.
- R5: chip_trig_o pulses exactly Dt cycles after accept_o, and ro_start_o pulses exactly Dr cycles after accept_o. Dt is set at address 3 and Dr at address 5. A delay of 0 makes the pulse coincide with accept_o.
- R6: When mode bit 1 is 1, test_pulse_o pulses Dp cycles after accept_o, with Dp set at address 4. When the bit is 0, test_pulse_o stays low.
- R7: When mode bit 0 is 1, chip_reset_o pulses in the same cycle as accept_o. When the bit is 0, chip_reset_o stays low.
- R8: With period value F (address 2), an external trigger whose accept_o would land fewer than F*64 cycles after the previous accept_o is ignored. A trigger landing exactly F*64 cycles later is accepted. F = 0 gives no hold-off.
- R9: A trigger that arrives while any delay countdown from the previous trigger is still running is ignored.
- R10: While run enable (address 6, bit 0) is 0, no trigger is accepted.
- R11: In internal mode (mode bit 2 = 0) with run enabled, accept_o repeats every F*64 cycles. The first pulse comes 2 cycles after the run write is issued. trig_in is ignored in this mode.
- R12: The reset defaults are mode 0x04 (external source, no test pulse, no reset pulse) and delays of 256, 128 and 300 cycles for chip trigger, test pulse and readout start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| trig_in | input | 1 | Asynchronous external trigger |
| accept_o | output | 1 | One-cycle pulse per accepted trigger |
| chip_trig_o | output | 1 | Delayed chip trigger pulse |
| test_pulse_o | output | 1 | Delayed test pulse |
| chip_reset_o | output | 1 | Chip reset pulse, coincident with acceptance |
| ro_start_o | output | 1 | Delayed readout-start pulse |
| burst_slots_o | output | 5 | Sample slots per trigger, (n+1)*3 |

## Verification
The chip-trigger and test-pulse countdowns can end in the same cycle. The bench provokes this by programming equal delays of 5 cycles with the test pulse enabled. The scoreboard holds both expected pulses for that single cycle and flags either one if it is missing or displaced. A second coincidence is the chip reset pulse landing on the accept cycle. Zero delays go further and put every output in the acceptance cycle at once. Each output is judged separately against its own expected cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [2:0] {
    ADDR_MODE    = 3'd0,
    ADDR_BURST   = 3'd1,
    ADDR_PERIOD  = 3'd2,
    ADDR_TRG_DLY = 3'd3,
    ADDR_TP_DLY  = 3'd4,
    ADDR_RO_DLY  = 3'd5,
    ADDR_RUN     = 3'd6
  } cfg_addr_e;

  typedef struct packed {
    logic inv_pol;
    logic ext_src;
    logic tp_en;
    logic rst_en;
  } mode_t;

  localparam int NUM_LINES = 3;
  localparam int LINE_TRG  = 0;
  localparam int LINE_TP   = 1;
  localparam int LINE_RO   = 2;

endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ts_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DLY_W       = 16,
  parameter int PER_W       = 16,
  parameter int BURST_W     = 4,
  parameter int BURST_MAX   = 9,
  parameter logic [3:0] DEF_MODE = 4'h4,
  parameter int DEF_BURST   = 4,
  parameter int DEF_PERIOD  = 40000,
  parameter int DEF_TRG_DLY = 256,
  parameter int DEF_TP_DLY  = 128,
  parameter int DEF_RO_DLY  = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output mode_t             mode,
  output logic [BURST_W-1:0] burst_n,
  output logic [PER_W-1:0]  period,
  output logic [DLY_W-1:0]  dly_trg,
  output logic [DLY_W-1:0]  dly_tp,
  output logic [DLY_W-1:0]  dly_ro,
  output logic              run
);

  mode_t              mode_q, mode_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic [PER_W-1:0]   per_q, per_d;
  logic [DLY_W-1:0]   trg_q, trg_d, tp_q, tp_d, ro_q, ro_d;
  logic               run_q, run_d;

  always_comb begin
    mode_d  = mode_q;
    burst_d = burst_q;
    per_d   = per_q;
    trg_d   = trg_q;
    tp_d    = tp_q;
    ro_d    = ro_q;
    run_d   = run_q;
    if (we) begin
      case (cfg_addr_e'(addr))
        ADDR_MODE:    mode_d = mode_t'(wdata[3:0]);
        ADDR_BURST:   burst_d = (wdata > DATA_W'(BURST_MAX)) ? BURST_W'(BURST_MAX)
                                                             : wdata[BURST_W-1:0];
        ADDR_PERIOD:  per_d = PER_W'(wdata);
        ADDR_TRG_DLY: trg_d = DLY_W'(wdata);
        ADDR_TP_DLY:  tp_d  = DLY_W'(wdata);
        ADDR_RO_DLY:  ro_d  = DLY_W'(wdata);
        ADDR_RUN:     run_d = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= mode_t'(DEF_MODE);
      burst_q <= BURST_W'(DEF_BURST);
      per_q   <= PER_W'(DEF_PERIOD);
      trg_q   <= DLY_W'(DEF_TRG_DLY);
      tp_q    <= DLY_W'(DEF_TP_DLY);
      ro_q    <= DLY_W'(DEF_RO_DLY);
      run_q   <= 1'b0;
    end else if (we) begin
      mode_q  <= mode_d;
      burst_q <= burst_d;
      per_q   <= per_d;
      trg_q   <= trg_d;
      tp_q    <= tp_d;
      ro_q    <= ro_d;
      run_q   <= run_d;
    end
  end

  assign mode    = mode_q;
  assign burst_n = burst_q;
  assign period  = per_q;
  assign dly_trg = trg_q;
  assign dly_tp  = tp_q;
  assign dly_ro  = ro_q;
  assign run     = run_q;

  assert_burst_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q <= BURST_W'(BURST_MAX));

endmodule

// File: rtl/ts_trig_front.sv
module ts_trig_front (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic inv_pol,
  output logic rise
);

  logic meta_q, sync_q, lvl_q;
  logic lvl;

  always_comb begin
    lvl  = sync_q ^ inv_pol;
    rise = lvl & ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      meta_q <= trig_in;
      sync_q <= meta_q;
      lvl_q  <= lvl;
    end
  end

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ts_period_timer.sv
module ts_period_timer #(
  parameter int PER_W       = 16,
  parameter int SCALE_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             load,
  output logic             expired
);

  localparam int CNT_W = PER_W + SCALE_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] reload;
  logic             cnt_en;

  always_comb begin
    reload  = (period == '0) ? '0 : ({period, {SCALE_SHIFT{1'b0}}} - CNT_W'(1));
    expired = (cnt_q == '0);
    cnt_en  = load | ~expired;
    cnt_d   = load ? reload : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_load_on_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired);

  assert_countdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/ts_delay_line.sv
module ts_delay_line #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  input  logic             out_en,
  output logic             pulse,
  output logic             busy
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             pulse_q, fire;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fire   = 1'b0;
    if (start) begin
      if (dly == '0) begin
        fire = 1'b1;
      end else begin
        busy_d = 1'b1;
        cnt_d  = dly - DLY_W'(1);
      end
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        fire   = 1'b1;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      pulse_q <= fire & out_en;
    end
  end

  assign pulse = pulse_q;
  assign busy  = busy_q;

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - DLY_W'(1)));

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import ts_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DLY_W       = 16,
  parameter int PER_W       = 16,
  parameter int SCALE_SHIFT = 6,
  parameter int BURST_W     = 4,
  parameter int BURST_MAX   = 9,
  parameter int SLOT_W      = $clog2((BURST_MAX + 1) * 3 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              trig_in,
  output logic              accept_o,
  output logic              chip_trig_o,
  output logic              test_pulse_o,
  output logic              chip_reset_o,
  output logic              ro_start_o,
  output logic [SLOT_W-1:0] burst_slots_o
);

  mode_t              mode;
  logic [BURST_W-1:0] burst_n;
  logic [PER_W-1:0]   period;
  logic [DLY_W-1:0]   dly_trg, dly_tp, dly_ro;
  logic               run;
  logic               rise, expired;
  logic               accept, ext_acc, int_acc;
  logic               accept_q, reset_q;

  logic [DLY_W-1:0]     line_dly [NUM_LINES];
  logic [NUM_LINES-1:0] line_en, line_pulse, line_busy;

  ts_cfg_regs #(
    .DATA_W(DATA_W), .DLY_W(DLY_W), .PER_W(PER_W),
    .BURST_W(BURST_W), .BURST_MAX(BURST_MAX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .burst_n(burst_n), .period(period),
    .dly_trg(dly_trg), .dly_tp(dly_tp), .dly_ro(dly_ro), .run(run)
  );

  ts_trig_front u_front (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .inv_pol(mode.inv_pol), .rise(rise)
  );

  ts_period_timer #(.PER_W(PER_W), .SCALE_SHIFT(SCALE_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(period), .load(accept), .expired(expired)
  );

  always_comb begin
    ext_acc = run & mode.ext_src & rise & expired & ~(|line_busy);
    int_acc = run & ~mode.ext_src & expired & ~(|line_busy);
    accept  = ext_acc | int_acc;
    line_dly[LINE_TRG] = dly_trg;
    line_dly[LINE_TP]  = dly_tp;
    line_dly[LINE_RO]  = dly_ro;
    line_en[LINE_TRG]  = 1'b1;
    line_en[LINE_TP]   = mode.tp_en;
    line_en[LINE_RO]   = 1'b1;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    ts_delay_line #(.DLY_W(DLY_W)) u_line (
      .clk(clk), .rst_n(rst_n), .start(accept), .dly(line_dly[i]),
      .out_en(line_en[i]), .pulse(line_pulse[i]), .busy(line_busy[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      reset_q  <= 1'b0;
    end else begin
      accept_q <= accept;
      reset_q  <= accept & mode.rst_en;
    end
  end

  assign accept_o      = accept_q;
  assign chip_reset_o  = reset_q;
  assign chip_trig_o   = line_pulse[LINE_TRG];
  assign test_pulse_o  = line_pulse[LINE_TP];
  assign ro_start_o    = line_pulse[LINE_RO];
  assign burst_slots_o = SLOT_W'((burst_n + 1) * 3);

  assert_reset_with_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset_o |-> accept_o);

  assert_run_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> $past(run));

  assert_single_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && mode.ext_src && $past(mode.ext_src)) |=> !accept_o);

endmodule

// File: tb/sim_trig_sequencer.sv
module sim_trig_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        trig_in;
  logic        accept_o, chip_trig_o, test_pulse_o, chip_reset_o, ro_start_o;
  logic [4:0]  burst_slots_o;

  always #2 clk = ~clk;

  trig_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_in(trig_in), .accept_o(accept_o),
    .chip_trig_o(chip_trig_o), .test_pulse_o(test_pulse_o),
    .chip_reset_o(chip_reset_o), .ro_start_o(ro_start_o),
    .burst_slots_o(burst_slots_o)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          kind;
    int unsigned at;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails = 0;
  bit          mon_on = 0;
  bit          done = 0;
  int unsigned last_wr = 0;

  // reference model state
  bit          m_run = 0;
  logic [3:0]  m_mode = 4'h4;
  int unsigned m_per = 40000, m_dt = 256, m_dtp = 128, m_dro = 300;
  int unsigned next_ok = 0;
  logic        lvl = 1'b0;

  string nm[5] = '{"accept_o (R3/R8/R9/R10/R11)", "chip_trig_o (R5)",
                   "test_pulse_o (R6)", "chip_reset_o (R7)", "ro_start_o (R5)"};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input int unsigned at, input string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  task automatic note_accept(input int unsigned a, input string tag);
    push(0, a, tag);
    push(1, a + m_dt, (tag == "R12") ? "R12" : "R5");
    if (m_mode[1]) push(2, a + m_dtp, "R6");
    if (m_mode[0]) push(3, a, "R7");
    push(4, a + m_dro, (tag == "R12") ? "R12" : "R5");
    next_ok = a + m_per * 64;
    if (m_dt  > 0) next_ok = umax(next_ok, a + m_dt + 1);
    if (m_dtp > 0) next_ok = umax(next_ok, a + m_dtp + 1);
    if (m_dro > 0) next_ok = umax(next_ok, a + m_dro + 1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    last_wr = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      3'd0: m_mode = d[3:0];
      3'd2: m_per = d;
      3'd3: m_dt = d;
      3'd4: m_dtp = d;
      3'd5: m_dro = d;
      3'd6: m_run = d[0];
      default: ;
    endcase
  endtask

  task automatic set_trig(input logic v, input string tag);
    logic old_c, new_c;
    @(negedge clk);
    old_c = lvl ^ m_mode[3];
    new_c = v ^ m_mode[3];
    trig_in = v;
    lvl = v;
    if (!old_c && new_c && m_run && m_mode[2] && (cyc + 3 >= next_ok))
      note_accept(cyc + 3, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compare each output against the scoreboard every cycle
  always @(negedge clk) begin
    if (mon_on) begin
      logic [4:0] obs;
      obs = {ro_start_o, chip_reset_o, test_pulse_o, chip_trig_o, accept_o};
      for (int k = 0; k < 5; k++) begin
        int idx;
        idx = -1;
        for (int i = 0; i < q.size(); i++) begin
          if (idx < 0 && q[i].kind == k && q[i].at == cyc) idx = i;
        end
        if (idx >= 0) begin
          checks++;
          if (!obs[k]) begin
            fails++;
            $display("FAIL %s %s at cycle %0d actual=0 expected=1", q[idx].req, nm[k], cyc);
          end
          q.delete(idx);
        end else if (obs[k]) begin
          checks++;
          fails++;
          $display("FAIL %s unexpected pulse at cycle %0d actual=1 expected=0", nm[k], cyc);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned a0, a1, p;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; trig_in = 1'b0;
    idle(4);
    chk(accept_o == 0 && chip_trig_o == 0 && ro_start_o == 0, "R1", accept_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({accept_o, chip_trig_o, test_pulse_o, chip_reset_o, ro_start_o} == 5'b0,
        "R1", {accept_o, chip_trig_o, test_pulse_o, chip_reset_o, ro_start_o}, 0);
    chk(burst_slots_o == 15, "R1", burst_slots_o, 15);
    mon_on = 1;

    // R12: default mode and delays, short hold-off
    wr(3'd2, 16'd1);
    wr(3'd6, 16'd1);
    set_trig(1'b1, "R12");
    idle(3);
    set_trig(1'b0, "R12");
    idle(100);
    set_trig(1'b1, "R9");   // delays still running: ignored (R9)
    idle(2);
    set_trig(1'b0, "R9");
    idle(300);

    // R2: burst slot count
    wr(3'd1, 16'd7);  chk(burst_slots_o == 24, "R2", burst_slots_o, 24);
    wr(3'd1, 16'd12); chk(burst_slots_o == 30, "R2", burst_slots_o, 30);
    wr(3'd1, 16'd0);  chk(burst_slots_o == 3,  "R2", burst_slots_o, 3);
    wr(3'd1, 16'd9);  chk(burst_slots_o == 30, "R2", burst_slots_o, 30);

    // R5/R6/R7: equal trigger and test-pulse delays; R8 hold-off boundaries
    wr(3'd3, 16'd5);
    wr(3'd4, 16'd5);
    wr(3'd5, 16'd9);
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h7);
    set_trig(1'b1, "R3");
    a0 = cyc + 3;
    idle(1);
    set_trig(1'b0, "R3");
    wait_until(a0 + 46);
    set_trig(1'b1, "R8");   // lands at a0+50: inside hold-off
    idle(1);
    set_trig(1'b0, "R8");
    wait_until(a0 + 123);
    set_trig(1'b1, "R8");   // lands at a0+127: one short of hold-off end
    idle(1);
    set_trig(1'b0, "R8");
    wait_until(a0 + 199);
    set_trig(1'b1, "R3");
    a1 = cyc + 3;
    idle(1);
    set_trig(1'b0, "R3");
    wait_until(a1 + 124);
    set_trig(1'b1, "R8");   // lands exactly at a1+128: accepted
    idle(1);
    set_trig(1'b0, "R8");
    idle(150);

    // R8: no hold-off with period 0, zero delays
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd0);
    wr(3'd5, 16'd0);
    wr(3'd2, 16'd0);
    set_trig(1'b1, "R8");
    idle(1);
    set_trig(1'b0, "R8");
    idle(1);
    set_trig(1'b1, "R8");
    idle(1);
    set_trig(1'b0, "R8");
    idle(10);

    // R10 then R4: inverted polarity
    wr(3'd6, 16'd0);
    set_trig(1'b1, "R10");  // run off: ignored
    idle(6);
    wr(3'd0, 16'hC);
    wr(3'd6, 16'd1);
    idle(3);
    set_trig(1'b0, "R4");   // falling edge triggers
    idle(3);
    set_trig(1'b1, "R4");
    idle(5);
    set_trig(1'b0, "R4");
    idle(10);
    wr(3'd0, 16'h4);
    idle(5);

    // R11: internal generator
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd3);
    wr(3'd5, 16'd6);
    wr(3'd2, 16'd1);
    wr(3'd6, 16'd0);
    wr(3'd0, 16'h3);
    wr(3'd6, 16'd1);
    p = last_wr;
    note_accept(p + 2, "R11");
    note_accept(p + 66, "R11");
    note_accept(p + 130, "R11");
    wait_until(p + 20);
    set_trig(1'b1, "R11");  // ignored in internal mode
    idle(2);
    set_trig(1'b0, "R11");
    wait_until(p + 140);
    wr(3'd6, 16'd0);
    idle(100);

    foreach (q[i]) begin
      checks++;
      fails++;
      $display("FAIL %s missing %s at cycle %0d actual=0 expected=1", q[i].req, nm[q[i].kind], q[i].at);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule